// File: doc/BRIEF.md
# Interrupt status unit with two-stage gating

This block turns short event pulses from a transfer engine's transmit and receive FIFOs and from its descriptor processor into sticky status bits, and reduces them to one interrupt line. Two masks stand between an event and the line. The event-enable mask decides which status bits may latch at all, and clearing one of its bits also drops that status bit. The line-enable mask decides which latched bits may drive the interrupt output. Software sees a status bit only if its event-enable bit is set. Software stops a repeating interrupt by clearing the enable bit of the source it has handled.

The block also holds a transmit threshold and a receive threshold, and compares them with the FIFO fill levels. The results are two of the status sources: the transmit FIFO running low and the receive FIFO filling up. Software reaches everything through a word-addressed register port with a write strobe and a combinational read. A self-clearing soft-reset bit returns all state to zero.

Register word addresses: 0 control, 1 thresholds, 2 event enable, 3 status (read-only), 4 line enable. All other addresses read zero.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low, so the masks and both thresholds start at zero.
- R2: Events set these status bits: tx empty bit 0, tx full bit 1, tx threshold bit 2, rx empty bit 3, rx full bit 4, rx threshold bit 5, descriptor done bit 9, packet complete bit 10, DMA error bit 11. Bits 6 to 8 and 12 and above always read zero.
- R3: A latched status bit stays set after its event ends, until its event-enable bit is cleared or a soft reset occurs.
- R4: A status bit latches only if its event-enable bit holds the new mask value, which is the value written in the same cycle when there is a write. Clearing an enable bit clears that status bit at the same clock edge.
- R5: The event-enable and line-enable registers keep only the implemented bits (mask 0xE3F). Other written bits read back zero.
- R6: `irq` is high exactly when some bit is set in status, in event enable and in line enable. It changes at the same clock edge as the state that causes it.
- R7: The threshold register (address 1) holds the tx threshold in bits 12:8 and the rx threshold in bits 4:0. Other bits read zero.
- R8: The tx threshold event fires while the tx level is at or below the tx threshold. The rx threshold event fires while the rx level is at or above the rx threshold.
- R9: Writing 1 to bit 16 of the control register (address 0) makes that bit read 1 for exactly one cycle. At the end of that cycle every register, including the bit itself, becomes zero, and any event or write during that cycle is ignored.
- R10: The status register (address 3) is read-only: writes to it have no effect. A status read of zero means no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_empty_ev | input | 1 | Transmit FIFO empty event pulse |
| tx_full_ev | input | 1 | Transmit FIFO full event pulse |
| rx_empty_ev | input | 1 | Receive FIFO empty event pulse |
| rx_full_ev | input | 1 | Receive FIFO full event pulse |
| desc_done_ev | input | 1 | Descriptor finished event pulse |
| pkt_done_ev | input | 1 | Packet finished event pulse |
| dma_err_ev | input | 1 | DMA error event pulse |
| irq | output | 1 | Gated interrupt line |

## Verification
Two functions can land in the same cycle: an event pulse and a software write that changes the event-enable mask for that event's bit. The bench provokes this by driving the write strobe and the event pulse in the same cycle, once with the write setting the enable bit and once with the write clearing it. It then reads status back: the bit is expected set in the first case and clear in the second. Soft reset is judged in the same way: the control bit must read 1 during its single cycle, and every register must read zero in the cycle after.

// File: rtl/isr_pkg.sv
package isr_pkg;

    // status vector geometry
    localparam int STAT_W = 12;

    // status bit positions (software decodes these)
    localparam int B_TX_EMPTY  = 0;
    localparam int B_TX_FULL   = 1;
    localparam int B_TX_THR    = 2;
    localparam int B_RX_EMPTY  = 3;
    localparam int B_RX_FULL   = 4;
    localparam int B_RX_THR    = 5;
    localparam int B_DESC_DONE = 9;
    localparam int B_PKT_DONE  = 10;
    localparam int B_DMA_ERR   = 11;

    // implemented status bits
    localparam logic [STAT_W-1:0] STAT_IMPL = 12'hE3F;

    // register word addresses
    localparam int ADR_CTRL   = 0;
    localparam int ADR_THRESH = 1;
    localparam int ADR_EVEN   = 2;
    localparam int ADR_STATUS = 3;
    localparam int ADR_LINEEN = 4;

    // field positions
    localparam int SRST_BIT = 16;
    localparam int TXT_LSB  = 8;
    localparam int RXT_LSB  = 0;

endpackage

// File: rtl/isr_level_cmp.sv
module isr_level_cmp #(
    parameter int LVL_W = 6,
    parameter int THR_W = 5
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic             tx_hit,
    output logic             rx_hit
);
    localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

    logic [CW-1:0] tx_lvl_x, rx_lvl_x, tx_thr_x, rx_thr_x;

    always_comb begin
        tx_lvl_x = CW'(tx_level);
        rx_lvl_x = CW'(rx_level);
        tx_thr_x = CW'(tx_thr);
        rx_thr_x = CW'(rx_thr);
        // transmit side runs low, receive side fills up
        tx_hit   = (tx_lvl_x <= tx_thr_x);
        rx_hit   = (rx_lvl_x >= rx_thr_x);
    end

endmodule

// File: rtl/isr_event_map.sv
module isr_event_map
    import isr_pkg::*;
(
    input  logic              tx_empty_ev,
    input  logic              tx_full_ev,
    input  logic              tx_hit,
    input  logic              rx_empty_ev,
    input  logic              rx_full_ev,
    input  logic              rx_hit,
    input  logic              desc_done_ev,
    input  logic              pkt_done_ev,
    input  logic              dma_err_ev,
    output logic [STAT_W-1:0] raw_ev
);
    always_comb begin
        raw_ev              = '0;
        raw_ev[B_TX_EMPTY]  = tx_empty_ev;
        raw_ev[B_TX_FULL]   = tx_full_ev;
        raw_ev[B_TX_THR]    = tx_hit;
        raw_ev[B_RX_EMPTY]  = rx_empty_ev;
        raw_ev[B_RX_FULL]   = rx_full_ev;
        raw_ev[B_RX_THR]    = rx_hit;
        raw_ev[B_DESC_DONE] = desc_done_ev;
        raw_ev[B_PKT_DONE]  = pkt_done_ev;
        raw_ev[B_DMA_ERR]   = dma_err_ev;
    end

endmodule

// File: rtl/isr_read_mux.sv
module isr_read_mux
    import isr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int THR_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              srst,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic [STAT_W-1:0] en,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] line,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(ADR_THRESH);
    localparam logic [ADDR_W-1:0] A_EVEN   = ADDR_W'(ADR_EVEN);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
    localparam logic [ADDR_W-1:0] A_LINEEN = ADDR_W'(ADR_LINEEN);

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[SRST_BIT] = srst;
            A_THRESH: begin
                rdata[TXT_LSB +: THR_W] = tx_thr;
                rdata[RXT_LSB +: THR_W] = rx_thr;
            end
            A_EVEN:   rdata[STAT_W-1:0] = en;
            A_STATUS: rdata[STAT_W-1:0] = status;
            A_LINEEN: rdata[STAT_W-1:0] = line;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int THR_W  = 5,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_empty_ev,
    input  logic              tx_full_ev,
    input  logic              rx_empty_ev,
    input  logic              rx_full_ev,
    input  logic              desc_done_ev,
    input  logic              pkt_done_ev,
    input  logic              dma_err_ev,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(ADR_THRESH);
    localparam logic [ADDR_W-1:0] A_EVEN   = ADDR_W'(ADR_EVEN);
    localparam logic [ADDR_W-1:0] A_LINEEN = ADDR_W'(ADR_LINEEN);

    typedef struct packed {
        logic              srst;
        logic [THR_W-1:0]  tx_thr;
        logic [THR_W-1:0]  rx_thr;
        logic [STAT_W-1:0] en;
        logic [STAT_W-1:0] line;
        logic [STAT_W-1:0] status;
        logic              irq;
    } state_t;

    state_t st_d, st_q;

    logic              tx_hit, rx_hit;
    logic [STAT_W-1:0] raw_ev;

    // observation taps for the bound checker
    logic              srst_w;
    logic [THR_W-1:0]  tx_thr_w, rx_thr_w;
    logic [STAT_W-1:0] en_w, line_w, status_w;

    wire unused_wdata_bits = ^reg_wdata;

    isr_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (st_q.tx_thr),
        .rx_thr   (st_q.rx_thr),
        .tx_hit   (tx_hit),
        .rx_hit   (rx_hit)
    );

    isr_event_map u_map (
        .tx_empty_ev  (tx_empty_ev),
        .tx_full_ev   (tx_full_ev),
        .tx_hit       (tx_hit),
        .rx_empty_ev  (rx_empty_ev),
        .rx_full_ev   (rx_full_ev),
        .rx_hit       (rx_hit),
        .desc_done_ev (desc_done_ev),
        .pkt_done_ev  (pkt_done_ev),
        .dma_err_ev   (dma_err_ev),
        .raw_ev       (raw_ev)
    );

    isr_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .THR_W(THR_W)) u_rd (
        .addr   (reg_addr),
        .srst   (st_q.srst),
        .tx_thr (st_q.tx_thr),
        .rx_thr (st_q.rx_thr),
        .en     (st_q.en),
        .status (st_q.status),
        .line   (st_q.line),
        .rdata  (reg_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.srst) begin
            // soft reset cycle: everything returns to zero
            st_d = '0;
        end else begin
            if (reg_wen) begin
                case (reg_addr)
                    A_CTRL:   st_d.srst = reg_wdata[SRST_BIT];
                    A_THRESH: begin
                        st_d.tx_thr = reg_wdata[TXT_LSB +: THR_W];
                        st_d.rx_thr = reg_wdata[RXT_LSB +: THR_W];
                    end
                    A_EVEN:   st_d.en   = reg_wdata[STAT_W-1:0] & STAT_IMPL;
                    A_LINEEN: st_d.line = reg_wdata[STAT_W-1:0] & STAT_IMPL;
                    default:  ;
                endcase
            end
            // latch against the mask that will hold after this edge
            st_d.status = (st_q.status | raw_ev) & st_d.en;
            st_d.irq    = |(st_d.status & st_d.en & st_d.line);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq      = st_q.irq;
    assign srst_w   = st_q.srst;
    assign tx_thr_w = st_q.tx_thr;
    assign rx_thr_w = st_q.rx_thr;
    assign en_w     = st_q.en;
    assign line_w   = st_q.line;
    assign status_w = st_q.status;

endmodule

// File: rtl/isr_checker.sv
module isr_checker
    import isr_pkg::*;
#(
    parameter int THR_W = 5,
    parameter int LVL_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic              srst,
    input logic [THR_W-1:0]  tx_thr,
    input logic [THR_W-1:0]  rx_thr,
    input logic [STAT_W-1:0] en,
    input logic [STAT_W-1:0] line,
    input logic [STAT_W-1:0] status,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic              irq
);
    localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

    // R4: no status bit outside the event-enable mask
    assert_status_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~en) == '0);

    // R2: unimplemented status positions never set
    assert_reserved_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~STAT_IMPL) == '0);

    // R3: without a write or soft reset, latched bits stay latched
    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wen && !srst) |=> ((status & $past(status)) == $past(status)));

    // R6: line equals the three-way overlap
    assert_line_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(status & en & line)));

    // R9: soft reset clears all state within one cycle
    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!srst && status == '0 && en == '0 && line == '0
                  && tx_thr == '0 && rx_thr == '0 && !irq));

    // R8: tx level at or below threshold latches bit 2 when enabled
    assert_tx_thresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !reg_wen && en[B_TX_THR] && (CW'(tx_level) <= CW'(tx_thr)))
        |=> status[B_TX_THR]);

    // R8: rx level at or above threshold latches bit 5 when enabled
    assert_rx_thresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !reg_wen && en[B_RX_THR] && (CW'(rx_level) >= CW'(rx_thr)))
        |=> status[B_RX_THR]);

endmodule

bind irq_status_unit isr_checker #(.THR_W(THR_W), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wen  (reg_wen),
    .srst     (srst_w),
    .tx_thr   (tx_thr_w),
    .rx_thr   (rx_thr_w),
    .en       (en_w),
    .line     (line_w),
    .status   (status_w),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .irq      (irq)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  tx_level = 6'd10;
    logic [5:0]  rx_level = 6'd5;
    logic [6:0]  evs = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // event vector bits
    localparam logic [6:0] E_TXE = 7'h01, E_TXF = 7'h02, E_RXE = 7'h04,
                           E_RXF = 7'h08, E_DD  = 7'h10, E_PKT = 7'h20,
                           E_ERR = 7'h40;
    localparam logic [2:0] A_CTRL = 3'd0, A_THR = 3'd1, A_EN = 3'd2,
                           A_ST = 3'd3, A_LINE = 3'd4;

    always #2.5 clk = ~clk;

    irq_status_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wen      (reg_wen),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .tx_level     (tx_level),
        .rx_level     (rx_level),
        .tx_empty_ev  (evs[0]),
        .tx_full_ev   (evs[1]),
        .rx_empty_ev  (evs[2]),
        .rx_full_ev   (evs[3]),
        .desc_done_ev (evs[4]),
        .pkt_done_ev  (evs[5]),
        .dma_err_ev   (evs[6]),
        .irq          (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    item_t mon_it;
    logic [31:0] mon_act;

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            mon_it  = sb.pop_front();
            mon_act = mon_it.is_irq ? {31'b0, irq} : reg_rdata;
            n_chk++;
            if (mon_act !== mon_it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", mon_it.tag, mon_act, mon_it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [6:0] ev);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1; evs = ev;
        @(posedge clk); #1;
        reg_wen = 1'b0; evs = '0;
    endtask

    task automatic pulse(input logic [6:0] ev);
        evs = ev;
        @(posedge clk); #1;
        evs = '0;
    endtask

    task automatic exp_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1: reset state
        exp_reg(A_CTRL, 32'h0, "R1 ctrl");
        exp_reg(A_THR,  32'h0, "R1 thresholds");
        exp_reg(A_EN,   32'h0, "R1 event enable");
        exp_reg(A_LINE, 32'h0, "R1 line enable");
        exp_reg(A_ST,   32'h0, "R10 status empty after reset");
        exp_irq(1'b0, "R1 irq low");

        // R7: threshold layout
        wr(A_THR, 32'hFFFF_FFFF, 7'h0);
        exp_reg(A_THR, 32'h0000_1F1F, "R7 threshold fields");
        wr(A_THR, 32'h0000_0414, 7'h0);
        exp_reg(A_THR, 32'h0000_0414, "R7 tx=4 rx=20");

        // R5: enable mask keeps implemented bits
        wr(A_EN, 32'hFFFF_FFFF, 7'h0);
        exp_reg(A_EN, 32'h0000_0E3F, "R5 enable mask");
        exp_reg(A_ST, 32'h0, "R8 no threshold hit at tx10 rx5");

        // R2 + R6: latch but line gate closed
        pulse(E_PKT);
        exp_reg(A_ST, 32'h0000_0400, "R2 packet bit 10");
        exp_irq(1'b0, "R6 line mask closed");
        wr(A_LINE, 32'hFFFF_F400, 7'h0);
        exp_reg(A_LINE, 32'h0000_0400, "R5 line mask");
        exp_irq(1'b1, "R6 line opened");

        // R3: sticky
        idle(3);
        pulse(E_PKT);
        exp_reg(A_ST, 32'h0000_0400, "R3 sticky");
        pulse(E_ERR);
        exp_reg(A_ST, 32'h0000_0C00, "R2 dma error bit 11");

        // R10: status write ignored
        wr(A_ST, 32'h0, 7'h0);
        exp_reg(A_ST, 32'h0000_0C00, "R10 status read-only");

        // R4: clearing enable drops status
        wr(A_EN, 32'h0000_023F, 7'h0);
        exp_reg(A_ST, 32'h0, "R4 clear enable clears status");
        exp_irq(1'b0, "R6 irq low after clear");
        pulse(E_PKT);
        exp_reg(A_ST, 32'h0, "R4 disabled event ignored");

        // R2: all pulse events together
        wr(A_EN, 32'h0000_0E3F, 7'h0);
        pulse(E_TXE | E_TXF | E_RXE | E_RXF | E_DD | E_PKT | E_ERR);
        exp_reg(A_ST, 32'h0000_0E1B, "R2 all event positions");

        // R8: threshold boundaries
        wr(A_EN, 32'h0, 7'h0);
        exp_reg(A_ST, 32'h0, "R4 mask zero");
        wr(A_EN, 32'h0000_0024, 7'h0);
        tx_level = 6'd5; idle(1);
        exp_reg(A_ST, 32'h0, "R8 tx level above threshold");
        tx_level = 6'd4; idle(1);
        exp_reg(A_ST, 32'h0000_0004, "R8 tx level equal threshold");
        tx_level = 6'd10;
        rx_level = 6'd19; idle(1);
        exp_reg(A_ST, 32'h0000_0004, "R8 rx below threshold, R3 tx held");
        rx_level = 6'd20; idle(1);
        exp_reg(A_ST, 32'h0000_0024, "R8 rx level equal threshold");
        rx_level = 6'd5; idle(1);

        // R6: two gates
        wr(A_LINE, 32'h0000_0020, 7'h0);
        exp_irq(1'b1, "R6 rx threshold to line");
        wr(A_EN, 32'h0000_0004, 7'h0);
        exp_reg(A_ST, 32'h0000_0004, "R4 status follows new mask");
        exp_irq(1'b0, "R6 set bit but line mask off");

        // R4: event in the same cycle as an enable write
        wr(A_EN, 32'h0, 7'h0);
        wr(A_EN, 32'h0000_0400, E_PKT);
        exp_reg(A_ST, 32'h0000_0400, "R4 event with enabling write");
        wr(A_EN, 32'h0000_0800, 7'h0);
        wr(A_EN, 32'h0, E_ERR);
        exp_reg(A_ST, 32'h0, "R4 event with disabling write");

        // R9: soft reset
        wr(A_EN, 32'h0000_0E3F, 7'h0);
        wr(A_LINE, 32'h0000_0E3F, 7'h0);
        pulse(E_ERR);
        exp_irq(1'b1, "R6 irq before soft reset");
        wr(A_CTRL, 32'h0001_0000, 7'h0);
        evs = E_PKT;
        exp_reg(A_CTRL, 32'h0001_0000, "R9 reset bit visible one cycle");
        evs = '0;
        exp_reg(A_CTRL, 32'h0, "R9 reset bit self-clears");
        exp_reg(A_EN,   32'h0, "R9 enable cleared");
        exp_reg(A_LINE, 32'h0, "R9 line cleared");
        exp_reg(A_THR,  32'h0, "R9 thresholds cleared");
        exp_reg(A_ST,   32'h0, "R9 status cleared");
        exp_irq(1'b0, "R9 irq low");

        idle(2);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule